// File: doc/BRIEF.md
# Execution Count Break Counter

This block sits beside the comparator of one hardware breakpoint channel and decides when a comparator hit becomes a break request. Software loads a 12-bit count through a 16-bit register port. While count-based breaking is enabled, every match lowers the count by one. The match that arrives when the count already reads one raises the break. When count-based breaking is disabled, every match is passed straight through as a break and the count is left as it is.

The break request is a registered pulse that lasts one cycle. It appears in the cycle after the qualifying match. The count does not wrap and does not go below one. To arm the block again, software writes a new count. The upper four bits of the register are fixed at zero.

Top module: `exec_count_break`

## Requirements
- R1: After reset, the register reads 0x0000 and `brk_req` is low.
- R2: A write stores `bus_wdata[11:0]` as the count. `bus_rdata[11:0]` returns the count and `bus_rdata[15:12]` always reads zero, whatever value was written to those bits.
- R3: A match with `count_en` high and a count greater than one lowers the count by one on the next clock edge and raises no break.
- R4: A match with `count_en` high and a count of one raises `brk_req` in the next cycle and leaves the count at one.
- R5: A count of zero behaves like a count of one. The match raises the break and the count stays zero.
- R6: With `count_en` low, every match raises `brk_req` in the next cycle and the count is not changed.
- R7: A write in the same cycle as a match takes priority over the decrement, so the written value is stored. The break decision in that cycle uses the count held before the write.
- R8: `brk_req` is high only in the cycle that directly follows a qualifying match. It is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data: count in bits 11:0, zero in bits 15:12 |
| count_en | input | 1 | Enables count-based breaking |
| match | input | 1 | Per-cycle comparator hit |
| brk_req | output | 1 | One-cycle break request |

## Verification
A software write and a comparator match can arrive in the same clock cycle. In that case the write has to win over the decrement, while the break decision still follows the count held before the write. The random phase raises write and match independently, at rates high enough that they often coincide. It also biases written counts toward 0, 1 and 2, so the coincidence is seen at the firing threshold. A directed case forces a write together with a match at count one. Every cycle is compared against a bench reference model that applies write priority and the old-count break rule.

// File: rtl/exec_count_break.sv
module exec_count_break #(
  parameter int REG_W = 16,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             count_en,
  input  logic             match,
  output logic             brk_req
);

  localparam logic [REG_W-1:0] CNT_MASK = REG_W'((1 << CNT_W) - 1);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [REG_W-1:0] reg_q;
  logic [CNT_W-1:0] cnt;
  logic             at_floor;
  logic             hit;
  logic             dec;

  assign cnt      = reg_q[CNT_W-1:0];
  assign at_floor = (cnt <= ONE);
  assign hit      = match & (~count_en | at_floor);
  assign dec      = match & count_en & ~at_floor;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_q   <= '0;
      brk_req <= 1'b0;
    end else begin
      brk_req <= hit;
      if (bus_wr)
        reg_q <= bus_wdata & CNT_MASK;
      else if (dec)
        reg_q <= reg_q - REG_W'(1);
    end
  end

  assign bus_rdata = reg_q;

endmodule

// File: rtl/exec_count_break_chk.sv
module exec_count_break_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [15:0] bus_wdata,
  input logic [15:0] bus_rdata,
  input logic        count_en,
  input logic        match,
  input logic        brk_req
);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[15:12] == 4'h0);

  assert_write_stores_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> bus_rdata[11:0] == $past(bus_wdata[11:0]));

  assert_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && match && !bus_wr && bus_rdata[11:0] > 12'd1)
      |=> (bus_rdata[11:0] == $past(bus_rdata[11:0]) - 12'd1) && !brk_req);

  assert_fire_at_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && match && !bus_wr && bus_rdata[11:0] == 12'd1)
      |=> brk_req && bus_rdata[11:0] == 12'd1);

  assert_zero_as_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && match && !bus_wr && bus_rdata[11:0] == 12'd0)
      |=> brk_req && bus_rdata[11:0] == 12'd0);

  assert_passthrough_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && match) |=> brk_req);

  assert_hold_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !bus_wr) |=> $stable(bus_rdata));

  assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> $past(match));

endmodule

bind exec_count_break exec_count_break_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .count_en(count_en), .match(match), .brk_req(brk_req)
);

// File: tb/exec_count_break_tb.sv
module exec_count_break_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        count_en = 1'b0;
  logic        match = 1'b0;
  logic        brk_req;

  int checks = 0;
  int failures = 0;
  logic [11:0] m_cnt = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exec_count_break u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .count_en(count_en), .match(match), .brk_req(brk_req)
  );

  function automatic logic exp_brk(logic en, logic m, logic [11:0] c);
    return m && (!en || c <= 12'd1);
  endfunction

  function automatic logic [11:0] exp_cnt(logic wr, logic [15:0] wd, logic en, logic m, logic [11:0] c);
    if (wr) return wd[11:0];
    if (m && en && c > 12'd1) return c - 12'd1;
    return c;
  endfunction

  function automatic string req_tag(logic wr, logic en, logic m, logic [11:0] c);
    if (wr && m) return "R7";
    if (wr) return "R2";
    if (m && !en) return "R6";
    if (m && c == 0) return "R5";
    if (m && c == 1) return "R4";
    if (m) return "R3";
    return "R8";
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic wr, logic [15:0] wd, logic en, logic m);
    logic        eb;
    logic [11:0] ec;
    string       tag;
    bus_wr = wr; bus_wdata = wd; count_en = en; match = m;
    eb  = exp_brk(en, m, m_cnt);
    ec  = exp_cnt(wr, wd, en, m, m_cnt);
    tag = req_tag(wr, en, m, m_cnt);
    @(posedge clk);
    @(negedge clk);
    m_cnt = ec;
    check(tag, {15'd0, brk_req}, {15'd0, eb});
    check(tag, bus_rdata, {4'h0, ec});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1", bus_rdata, 16'h0000);
    check("R1", {15'd0, brk_req}, 16'h0000);

    step(1'b1, 16'hF003, 1'b1, 1'b0);   // R2: reserved bits dropped
    step(1'b0, 16'h0, 1'b1, 1'b1);      // R3: 3 -> 2
    step(1'b0, 16'h0, 1'b1, 1'b0);      // R8: no match, no break
    step(1'b0, 16'h0, 1'b1, 1'b1);      // R3: 2 -> 1
    step(1'b0, 16'h0, 1'b1, 1'b1);      // R4: fire, hold 1
    step(1'b0, 16'h0, 1'b1, 1'b1);      // R4: fire again
    step(1'b0, 16'h0, 1'b0, 1'b1);      // R6: pass through
    step(1'b1, 16'h0000, 1'b1, 1'b0);   // R2
    step(1'b0, 16'h0, 1'b1, 1'b1);      // R5: zero fires
    step(1'b1, 16'h0FFF, 1'b1, 1'b0);   // R2: max
    step(1'b0, 16'h0, 1'b1, 1'b1);      // R3: 4095 -> 4094
    step(1'b1, 16'h0001, 1'b1, 1'b0);
    step(1'b1, 16'h0009, 1'b1, 1'b1);   // R7: fires on old 1, stores 9
    step(1'b1, 16'h0002, 1'b1, 1'b1);   // R7: old 9 no fire, stores 2

    for (int i = 0; i < 4000; i++) begin
      logic [15:0] wd;
      int sel = $urandom_range(0, 3);
      wd = $urandom();
      if (sel != 0) wd[11:0] = 12'($urandom_range(0, 3));
      step(($urandom_range(0, 5) == 0), wd, ($urandom_range(0, 7) != 0),
           ($urandom_range(0, 1) == 1));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule